// File: doc/BRIEF.md
# Synchronous Bus Clock Prescaler

This block derives the clock enables of four synchronous domains from a single main tick: a processor domain, a high-speed bus domain and two peripheral bus domains (A and B) that both hang below the high-speed bus. The main tick is taken from one of two source strobes, an oscillator strobe or a PLL strobe, picked by a select bit. Every domain has its own power-of-two divider. A domain's outputs are one-cycle enable strobes, not derived clocks, so all logic stays on the single fast clock `clk`.

Each domain also owns a mask word with one gate bit per attached module. A module's enable is its domain strobe ANDed with that module's mask bit. A small register port writes and reads the source select, the divider configuration, the masks and a sticky ordering-error flag.

The dividers share one free-running counter of main ticks. Because of this, every strobe is phase aligned with the strobes of its parent domain. A new divider setting is held pending and is loaded only at the point where the counter wraps to zero.

Top module: `bus_clk_prescaler`

## Requirements
- R1: The main tick equals `osc_tick` while bit 0 of the source register (address 0) is 0, and equals `pll_tick` while it is 1. No domain strobes when the selected source does not tick.
- R2: A domain whose divide-enable bit is 0 strobes on every main tick.
- R3: Address 1 holds one 4-bit field per domain: processor in bits 3:0, high-speed bus in 7:4, peripheral A in 11:8 and peripheral B in 15:12. In each field, bit 3 is the divide enable and bits 2:0 are the select value S. A domain with its divide enable set strobes once every 2^(S+1) main ticks, so the divisor ranges from 2 to 256.
- R4: Whenever the high-speed bus strobes, the processor strobes in the same cycle. Whenever either peripheral domain strobes, the high-speed bus strobes in the same cycle.
- R5: A domain configured faster than its parent runs at its parent's effective divisor. Writing such a configuration sets the sticky error flag. The flag is visible in bit 0 of address 2 and on `cfg_err`. Writing 1 to bit 0 of address 2 clears it. Writing 0 or writing a legal configuration leaves it set.
- R6: A divider change takes effect only on the main tick at which the shared counter is zero, and all four domains strobe on that tick. Before that tick the previous setting stays in force.
- R7: For each domain d and module i, `mod_en[d*NMOD+i]` is high exactly when domain d strobes and bit i of that domain's mask word is set. The mask words sit at addresses 4 to 7, in the order processor, high-speed bus, peripheral A, peripheral B.
- R8: After reset, the source select, the divider configuration, all masks and the error flag are zero, and no strobe occurs without a tick.
- R9: Registers read back the last value written, with unused bits reading zero.
- R10: A write to an unmapped address (3) changes no register, and reading an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator source strobe |
| pll_tick | input | 1 | PLL source strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| dom_en | output | 4 | Domain strobes: processor, high-speed bus, peripheral A, peripheral B |
| mod_en | output | 4*NMOD | Per-module gated strobes |
| cfg_err | output | 1 | Sticky rate-ordering error |

## Verification
The hardest situation to reach from the ports is a divider change that is pending while the shared counter sits partway through its 256-tick cycle. The cycle on which the new setting is loaded is not visible at the ports. The bench therefore starts this test straight after reset, when the counter is known to be zero. It issues exactly three main ticks, writes a divide-by-256 setting with no ticks during the write, and counts strobes tick by tick up to the wrap. The old rate must persist for 253 ticks, all domains must strobe on the wrap tick, and the next 255 ticks must stay silent.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
   localparam int NDOM = 4;
   localparam int DOM_CPU = 0;
   localparam int DOM_HSB = 1;
   localparam int DOM_PBA = 2;
   localparam int DOM_PBB = 3;

   localparam int ADR_MAIN  = 0;
   localparam int ADR_DIV   = 1;
   localparam int ADR_ERR   = 2;
   localparam int ADR_MASK0 = 4;

   function automatic int parent_of(input int d);
      case (d)
         DOM_CPU: return DOM_CPU;
         DOM_HSB: return DOM_CPU;
         default: return DOM_HSB;
      endcase
   endfunction
endpackage

// File: rtl/bcp_order_clamp.sv
module bcp_order_clamp
   import bcp_pkg::*;
#(
   parameter int SEL_W = 3,
   parameter int KW    = 4
) (
   input  logic [NDOM*(SEL_W+1)-1:0] div_req,
   output logic [NDOM*KW-1:0]        eff_k,
   output logic                      order_viol
);
   localparam int FW = SEL_W + 1;

   function automatic logic [NDOM*KW:0] clamp_fn(input logic [NDOM*FW-1:0] req);
      logic [KW-1:0] ek [NDOM];
      logic [KW-1:0] rk;
      logic [FW-1:0] fld;
      logic          bad;
      logic [NDOM*KW-1:0] flat;
      bad  = 1'b0;
      flat = '0;
      for (int d = 0; d < NDOM; d++) begin
         fld = req[d*FW +: FW];
         rk  = fld[SEL_W] ? (KW'(fld[SEL_W-1:0]) + KW'(1)) : '0;
         if (d == 0) begin
            ek[d] = rk;
         end else if (rk < ek[parent_of(d)]) begin
            ek[d] = ek[parent_of(d)];
            bad   = 1'b1;
         end else begin
            ek[d] = rk;
         end
         flat[d*KW +: KW] = ek[d];
      end
      return {bad, flat};
   endfunction

   always_comb begin
      {order_viol, eff_k} = clamp_fn(div_req);
   end
endmodule

// File: rtl/bcp_tick_gen.sv
module bcp_tick_gen
   import bcp_pkg::*;
#(
   parameter int SEL_W = 3,
   parameter int KW    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   main_tick,
   input  logic [NDOM*KW-1:0]     pend_k,
   output logic [NDOM-1:0]        dom_en,
   output logic [(2**SEL_W)-1:0]  cnt_o,
   output logic [NDOM*KW-1:0]     act_k_o
);
   localparam int CNT_W = 2**SEL_W;

   logic [CNT_W-1:0]   cnt_q;
   logic [NDOM*KW-1:0] act_q;
   logic               wrap_pt;

   assign wrap_pt = main_tick && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (main_tick) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (wrap_pt) begin
            act_q <= pend_k;
         end
      end
   end

   genvar d;
   generate
      for (d = 0; d < NDOM; d++) begin : g_dom
         logic [CNT_W-1:0] low_mask;
         assign low_mask  = ~({CNT_W{1'b1}} << act_q[d*KW +: KW]);
         assign dom_en[d] = main_tick && ((cnt_q & low_mask) == '0);
      end
   endgenerate

   assign cnt_o   = cnt_q;
   assign act_k_o = act_q;
endmodule

// File: rtl/bcp_gate.sv
module bcp_gate
   import bcp_pkg::*;
#(
   parameter int NMOD = 32
) (
   input  logic [NDOM-1:0]      dom_en,
   input  logic [NDOM*NMOD-1:0] masks,
   output logic [NDOM*NMOD-1:0] mod_en
);
   genvar d;
   generate
      for (d = 0; d < NDOM; d++) begin : g_dom
         assign mod_en[d*NMOD +: NMOD] = masks[d*NMOD +: NMOD] & {NMOD{dom_en[d]}};
      end
   endgenerate
endmodule

// File: rtl/bcp_regs.sv
module bcp_regs
   import bcp_pkg::*;
#(
   parameter int               ADDR_W   = 3,
   parameter int               DATA_W   = 32,
   parameter int               SEL_W    = 3,
   parameter int               NMOD     = 32,
   parameter logic [NMOD-1:0]  MASK_RST = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   input  logic                       order_viol,
   output logic                       pll_sel,
   output logic [NDOM*(SEL_W+1)-1:0]  div_req,
   output logic [NDOM*NMOD-1:0]       masks,
   output logic                       err
);
   localparam int DIVW = NDOM * (SEL_W + 1);

   logic div_wr_q;
   logic hit_main, hit_div, hit_err;

   assign hit_main = we && (addr == ADDR_W'(ADR_MAIN));
   assign hit_div  = we && (addr == ADDR_W'(ADR_DIV));
   assign hit_err  = we && (addr == ADDR_W'(ADR_ERR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_sel  <= 1'b0;
         div_req  <= '0;
         div_wr_q <= 1'b0;
         err      <= 1'b0;
      end else begin
         div_wr_q <= hit_div;
         if (hit_main) pll_sel <= wdata[0];
         if (hit_div)  div_req <= wdata[DIVW-1:0];
         if (hit_err && wdata[0]) err <= 1'b0;
         if (div_wr_q && order_viol) err <= 1'b1;
      end
   end

   genvar d;
   generate
      for (d = 0; d < NDOM; d++) begin : g_mask
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               masks[d*NMOD +: NMOD] <= MASK_RST;
            end else if (we && (addr == ADDR_W'(ADR_MASK0 + d))) begin
               masks[d*NMOD +: NMOD] <= wdata[NMOD-1:0];
            end
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_MAIN)) rdata = DATA_W'(pll_sel);
      if (addr == ADDR_W'(ADR_DIV))  rdata = DATA_W'(div_req);
      if (addr == ADDR_W'(ADR_ERR))  rdata = DATA_W'(err);
      for (int m = 0; m < NDOM; m++) begin
         if (addr == ADDR_W'(ADR_MASK0 + m)) rdata = DATA_W'(masks[m*NMOD +: NMOD]);
      end
   end
endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler
   import bcp_pkg::*;
#(
   parameter int               ADDR_W   = 3,
   parameter int               DATA_W   = 32,
   parameter int               SEL_W    = 3,
   parameter int               NMOD     = 32,
   parameter logic [NMOD-1:0]  MASK_RST = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   osc_tick,
   input  logic                   pll_tick,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata,
   output logic [3:0]             dom_en,
   output logic [4*NMOD-1:0]      mod_en,
   output logic                   cfg_err
);
   localparam int KW    = $clog2((2**SEL_W) + 1);
   localparam int CNT_W = 2**SEL_W;
   localparam int DIVW  = NDOM * (SEL_W + 1);

   generate
      if (NDOM != 4) begin : g_bad_ndom
         $error("domain count must be four");
      end
      if (DATA_W < NMOD || DATA_W < DIVW) begin : g_bad_dw
         $error("DATA_W too narrow for masks or divider fields");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W must reach the mask block");
      end
      if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
         $error("SEL_W out of supported range");
      end
   endgenerate

   logic                   pll_sel_q;
   logic                   main_tick;
   logic [DIVW-1:0]        div_req;
   logic [NDOM*KW-1:0]     pend_k;
   logic [NDOM*KW-1:0]     act_k;
   logic [CNT_W-1:0]       cnt_q;
   logic                   order_viol;
   logic [NDOM*NMOD-1:0]   masks;

   assign main_tick = pll_sel_q ? pll_tick : osc_tick;

   bcp_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
      .NMOD(NMOD), .MASK_RST(MASK_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .order_viol(order_viol),
      .pll_sel(pll_sel_q), .div_req(div_req), .masks(masks), .err(cfg_err)
   );

   bcp_order_clamp #(.SEL_W(SEL_W), .KW(KW)) u_clamp (
      .div_req(div_req), .eff_k(pend_k), .order_viol(order_viol)
   );

   bcp_tick_gen #(.SEL_W(SEL_W), .KW(KW)) u_tick (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .pend_k(pend_k),
      .dom_en(dom_en), .cnt_o(cnt_q), .act_k_o(act_k)
   );

   bcp_gate #(.NMOD(NMOD)) u_gate (
      .dom_en(dom_en), .masks(masks), .mod_en(mod_en)
   );
endmodule

// File: rtl/bcp_checker.sv
module bcp_checker
   import bcp_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 3,
   parameter int NMOD   = 32,
   parameter int KW     = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  osc_tick,
   input logic                  pll_tick,
   input logic                  pll_sel,
   input logic                  main_tick,
   input logic [(2**SEL_W)-1:0] cnt,
   input logic [NDOM*KW-1:0]    act_k,
   input logic [3:0]            dom_en,
   input logic [4*NMOD-1:0]     mod_en,
   input logic                  err,
   input logic                  reg_we,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [DATA_W-1:0]     reg_wdata
);
   AST_SRC_OSC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_sel && !osc_tick) |-> (dom_en == 4'b0)); // R1
   AST_SRC_PLL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_sel && !pll_tick) |-> (dom_en == 4'b0)); // R1
   AST_HSB_UNDER_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      dom_en[DOM_HSB] |-> dom_en[DOM_CPU]); // R4
   AST_PBA_UNDER_HSB: assert property (@(posedge clk) disable iff (!rst_n)
      dom_en[DOM_PBA] |-> dom_en[DOM_HSB]); // R4
   AST_PBB_UNDER_HSB: assert property (@(posedge clk) disable iff (!rst_n)
      dom_en[DOM_PBB] |-> dom_en[DOM_HSB]); // R4
   AST_ORDER_HSB: assert property (@(posedge clk) disable iff (!rst_n)
      act_k[DOM_HSB*KW +: KW] >= act_k[DOM_CPU*KW +: KW]); // R5
   AST_ORDER_PBA: assert property (@(posedge clk) disable iff (!rst_n)
      act_k[DOM_PBA*KW +: KW] >= act_k[DOM_HSB*KW +: KW]); // R5
   AST_ORDER_PBB: assert property (@(posedge clk) disable iff (!rst_n)
      act_k[DOM_PBB*KW +: KW] >= act_k[DOM_HSB*KW +: KW]); // R5
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(reg_we && reg_addr == ADDR_W'(ADR_ERR) && reg_wdata[0])) |=> err); // R5
   AST_APPLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (act_k != $past(act_k)) |-> $past(main_tick && cnt == '0)); // R6
   AST_ALL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (main_tick && cnt == '0) |-> (dom_en == 4'hF)); // R6

   genvar d;
   generate
      for (d = 0; d < NDOM; d++) begin : g_gate
         AST_MOD_NEEDS_DOM: assert property (@(posedge clk) disable iff (!rst_n)
            (mod_en[d*NMOD +: NMOD] != '0) |-> dom_en[d]); // R7
      end
   endgenerate
endmodule

bind bus_clk_prescaler bcp_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .NMOD(NMOD), .KW(KW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
   .pll_sel(pll_sel_q), .main_tick(main_tick), .cnt(cnt_q), .act_k(act_k),
   .dom_en(dom_en), .mod_en(mod_en), .err(cfg_err), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/bus_clk_prescaler_tb_top.sv
`timescale 1ns/1ps
module bus_clk_prescaler_tb_top;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 32;
   localparam int NMOD   = 32;

   // {div config, expected k for cpu/hsb/pba/pbb, expected error}
   localparam logic [32:0] VEC [6] = '{
      {16'h0000, 16'h0000, 1'b0},
      {16'h9A98, 16'h1232, 1'b0},
      {16'hC08B, 16'h4445, 1'b1},
      {16'hF900, 16'h0028, 1'b0},
      {16'h000F, 16'h8888, 1'b1},
      {16'hEAD0, 16'h0667, 1'b1}
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                osc_tick = 1'b0;
   logic                pll_tick = 1'b0;
   logic                reg_we = 1'b0;
   logic [ADDR_W-1:0]   reg_addr = '0;
   logic [DATA_W-1:0]   reg_wdata = '0;
   logic [DATA_W-1:0]   reg_rdata;
   logic [3:0]          dom_en;
   logic [4*NMOD-1:0]   mod_en;
   logic                cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   logic [NMOD-1:0] mask_m [4];

   always #2.5 clk = ~clk;

   bus_clk_prescaler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NMOD(NMOD)) dut_i (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .dom_en(dom_en), .mod_en(mod_en), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      osc_tick = 1'b0; pll_tick = 1'b0;
      reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      osc_tick = 1'b0; pll_tick = 1'b0; reg_we = 1'b0;
      reg_addr = ADDR_W'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic tick(input logic o, input logic p);
      @(negedge clk);
      reg_we = 1'b0;
      osc_tick = o; pll_tick = p;
      #1;
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] rv;
      int cnt_a;
      int cnts [4];
      int bad_ord, bad_gate;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8: reset state
      rd(0, rv); chk("R8 source select", rv, 0);
      rd(1, rv); chk("R8 divider config", rv, 0);
      rd(2, rv); chk("R8 error reg", rv, 0);
      rd(4, rv); chk("R8 mask cpu", rv, 0);
      rd(7, rv); chk("R8 mask pbb", rv, 0);
      #0 chk("R8 no strobe without tick", {28'b0, dom_en}, 0);

      // R2 and R6: counter is zero after reset
      cnt_a = 0;
      for (int i = 0; i < 3; i++) begin
         tick(1'b1, 1'b0);
         if (dom_en == 4'hF) cnt_a++;
      end
      chk("R2 undivided strobes every tick", cnt_a, 3);
      wr(1, 32'h0000_FFFF);
      cnt_a = 0;
      for (int i = 0; i < 253; i++) begin
         tick(1'b1, 1'b0);
         if (dom_en[0]) cnt_a++;
      end
      chk("R6 old rate holds before wrap", cnt_a, 253);
      tick(1'b1, 1'b0);
      chk("R6 all domains strobe at wrap", {28'b0, dom_en}, 32'hF);
      cnt_a = 0;
      for (int i = 0; i < 255; i++) begin
         tick(1'b1, 1'b0);
         if (dom_en != 4'h0) cnt_a++;
      end
      chk("R6 new rate after wrap", cnt_a, 0);

      // R1: source select
      wr(1, 32'h0);
      for (int i = 0; i < 256; i++) tick(1'b1, 1'b0);
      tick(1'b0, 1'b1); chk("R1 osc selected ignores pll", {28'b0, dom_en}, 0);
      tick(1'b1, 1'b0); chk("R1 osc selected follows osc", {28'b0, dom_en}, 32'hF);
      wr(0, 32'h1);
      tick(1'b1, 1'b0); chk("R1 pll selected ignores osc", {28'b0, dom_en}, 0);
      tick(1'b0, 1'b1); chk("R1 pll selected follows pll", {28'b0, dom_en}, 32'hF);
      rd(0, rv); chk("R1 source readback", rv, 1);
      wr(0, 32'h0);

      // masks
      mask_m[0] = 32'h0000_00A5; mask_m[1] = 32'h8000_0001;
      mask_m[2] = 32'h0F0F_0000; mask_m[3] = 32'hFFFF_FFFF;
      for (int d = 0; d < 4; d++) wr(4 + d, mask_m[d]);
      rd(5, rv); chk("R9 mask readback", rv, 32'h8000_0001);

      // vector table: R3 R4 R5 R7
      for (int v = 0; v < 6; v++) begin
         wr(2, 32'h1);
         wr(1, {16'h0, VEC[v][32:17]});
         rd(1, rv); chk("R9 divider readback", rv, {16'h0, VEC[v][32:17]});
         rd(2, rv); chk("R5 error flag after write", rv, {31'b0, VEC[v][0]});
         for (int i = 0; i < 256; i++) tick(1'b1, 1'b0);
         for (int d = 0; d < 4; d++) cnts[d] = 0;
         bad_ord = 0; bad_gate = 0;
         for (int i = 0; i < 256; i++) begin
            tick(1'b1, 1'b0);
            for (int d = 0; d < 4; d++) begin
               if (dom_en[d]) cnts[d]++;
               if (mod_en[d*NMOD +: NMOD] !== (dom_en[d] ? mask_m[d] : '0)) bad_gate++;
            end
            if ((dom_en[1] && !dom_en[0]) || (dom_en[2] && !dom_en[1]) ||
                (dom_en[3] && !dom_en[1])) bad_ord++;
         end
         for (int d = 0; d < 4; d++) begin
            chk("R3 strobe count per 256 ticks", cnts[d],
                256 >> int'(VEC[v][16-4*d -: 4]));
         end
         chk("R4 child strobe without parent", bad_ord, 0);
         chk("R7 module gating", bad_gate, 0);
      end

      // R5 stickiness
      wr(2, 32'h1);
      wr(1, 32'h0000_0008);
      rd(2, rv); chk("R5 violation sets flag", rv, 1);
      wr(1, 32'h0);
      @(negedge clk);
      rd(2, rv); chk("R5 legal write keeps flag", rv, 1);
      wr(2, 32'h0);
      #0 chk("R5 writing zero keeps flag", {31'b0, cfg_err}, 1);
      wr(2, 32'h1);
      rd(2, rv); chk("R5 write one clears flag", rv, 0);

      // R10 unmapped address
      wr(3, 32'hFFFF_FFFF);
      rd(3, rv); chk("R10 unmapped reads zero", rv, 0);
      rd(0, rv); chk("R10 source unchanged", rv, 0);
      rd(1, rv); chk("R10 divider unchanged", rv, 0);
      rd(2, rv); chk("R10 error unchanged", rv, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule